// File: doc/BRIEF.md
# Johnson-Coded Logarithmic LED Dimmer

This block dims a bank of LED lines with pulse-width modulation. An 8-bit switch word picks one of sixteen brightness steps. The word is read as a Johnson-sequence pattern, so moving one step up or down the scale flips exactly one switch. Each step maps to an 8-bit duty value on a perceptual, roughly logarithmic curve. The curve runs from fully on at step 1 to fully off at step 16.

A clock-enable prescaler divides the system clock into duty steps. A frame has 256 duty steps. With the default division (4 × 16 clocks per step) and a 3 MHz clock, the frame rate is about 183 Hz, which is well above the flicker threshold. Every frame opens with its dark phase and closes with its lit phase. The switch word is read only at a frame boundary, so a frame always completes with the level it started with. A flag reports whether the last sampled word was a legal code.

Top module: `dimmer_johnson_pwm`

## Requirements
- R1: Legal switch words and the steps they select (index = step − 1). Index i in 0..7 is the word whose i lowest bits are set and whose other bits are clear: 00h, 01h, 03h … 7Fh. Index 8+j for j in 0..7 is FFh with its j lowest bits cleared: FFh, FEh, FCh … 80h.
- R2: The duty values for indices 0..15 are FF, BF, 99, 7F, 6A, 5A, 4C, 3F, 34, 2B, 22, 1A, 13, 0C, 05, 00 (hex).
- R3: A frame is 256 duty steps, numbered 0 to 255. Each step lasts CLK_DIV × TICKS_PER_STEP clocks. For a duty d in 1..254, the output is low during steps 0..255−d and high during the last d steps, which gives d × CLK_DIV × TICKS_PER_STEP lit clocks per frame.
- R4: Duty FFh keeps the output high for every clock of the frame, and duty 00h keeps it low for every clock, with no pulse at either frame edge.
- R5: The switch word is sampled only on the clock edge that ends a frame. Changes between boundaries have no effect on the frame in progress.
- R6: If the sampled word is not one of the sixteen legal codes, the current step is kept and `level_ok_o` goes low. The next legal sample drives it high again.
- R7: All LED lines carry the same waveform on every clock.
- R8: Synchronous reset sets step 16 (dark) and drives `level_ok_o` high. It clears the prescaler and the step counter, so frame 0 begins on the first clock after release. That first frame is dark whatever the switches show.
- R9: A newly sampled step governs the output from the very first clock of the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sw_i | input | 8 | Johnson-coded brightness selector |
| led_o | output | LED_COUNT | PWM drive, all lines identical |
| level_ok_o | output | 1 | High when the last sampled word was a legal code |

## Verification
Counting from reset release, the frame boundaries fall on clock edge n × 256 × CLK_DIV × TICKS_PER_STEP. The new step and flag are visible right after such an edge, with no extra cycle of delay, and the LED level for a given step appears on the same edge that the step begins. For this reason the bench keeps its own count of edges since release and samples on falling edges. It places switch changes in mid-frame, and it totals the lit clocks over exactly one boundary-aligned frame. This means a result that arrived one cycle early or late, or a frame that was cut short, shows up as a wrong count or as a wrong first or last sample.

// File: rtl/dim_pkg.sv
package dim_pkg;

    localparam int SW_W    = 8;
    localparam int LVL_N   = 16;
    localparam int STEPS   = 256;

    typedef logic [3:0]      level_t;
    typedef logic [7:0]      duty_t;
    typedef logic [7:0]      step_t;
    typedef logic [SW_W-1:0] sw_t;

    typedef struct packed {
        logic   ok;
        level_t lvl;
    } sel_t;

    localparam level_t LEVEL_DARK = 4'd15;
    localparam duty_t  DUTY_FULL  = 8'hFF;
    localparam step_t  STEP_LAST  = 8'hFF;

    // Johnson pattern for a given index: fill from bit 0, then drain from bit 0.
    function automatic sw_t johnson_code(input level_t l);
        sw_t c;
        for (int b = 0; b < SW_W; b++) begin
            if (l[3])
                c[b] = (b >= int'(l[2:0]));
            else
                c[b] = (b < int'(l[2:0]));
        end
        return c;
    endfunction

    function automatic sel_t johnson_decode(input sw_t sw);
        sel_t r;
        r = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (sw == johnson_code(level_t'(i))) begin
                r.ok  = 1'b1;
                r.lvl = level_t'(i);
            end
        end
        return r;
    endfunction

    function automatic duty_t duty_of(input level_t l);
        duty_t d;
        case (l)
            4'd0:    d = 8'hFF;
            4'd1:    d = 8'hBF;
            4'd2:    d = 8'h99;
            4'd3:    d = 8'h7F;
            4'd4:    d = 8'h6A;
            4'd5:    d = 8'h5A;
            4'd6:    d = 8'h4C;
            4'd7:    d = 8'h3F;
            4'd8:    d = 8'h34;
            4'd9:    d = 8'h2B;
            4'd10:   d = 8'h22;
            4'd11:   d = 8'h1A;
            4'd12:   d = 8'h13;
            4'd13:   d = 8'h0C;
            4'd14:   d = 8'h05;
            default: d = 8'h00;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dim_prescaler.sv
module dim_prescaler #(
    parameter int CLK_DIV        = 4,
    parameter int TICKS_PER_STEP = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic step_en_o
);
    localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int TICK_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;

    logic tick;
    logic tick_wrap;

    generate
        if (CLK_DIV == 1) begin : g_div_pass
            assign tick = 1'b1;
        end else begin : g_div_cnt
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk_i) begin
                if (rst_i)
                    div_q <= '0;
                else if (div_q == DIV_W'(CLK_DIV - 1))
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DIV_W'(CLK_DIV - 1));
        end

        if (TICKS_PER_STEP == 1) begin : g_tick_pass
            assign tick_wrap = 1'b1;
        end else begin : g_tick_cnt
            logic [TICK_W-1:0] tick_q;
            always_ff @(posedge clk_i) begin
                if (rst_i)
                    tick_q <= '0;
                else if (tick) begin
                    if (tick_q == TICK_W'(TICKS_PER_STEP - 1))
                        tick_q <= '0;
                    else
                        tick_q <= tick_q + 1'b1;
                end
            end
            assign tick_wrap = (tick_q == TICK_W'(TICKS_PER_STEP - 1));
        end
    endgenerate

    assign step_en_o = tick && tick_wrap;

endmodule

// File: rtl/dim_frame.sv
module dim_frame
    import dim_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  step_en_i,
    output step_t step_q_o,
    output step_t step_nxt_o,
    output logic  frame_end_o
);
    assign step_nxt_o  = step_en_i ? step_q_o + 1'b1 : step_q_o;
    assign frame_end_o = step_en_i && (step_q_o == STEP_LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            step_q_o <= '0;
        else
            step_q_o <= step_nxt_o;
    end

endmodule

// File: rtl/dim_level_select.sv
module dim_level_select
    import dim_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  sw_t    sw_i,
    input  logic   frame_end_i,
    output level_t level_q_o,
    output level_t level_nxt_o,
    output logic   ok_o
);
    sel_t sel;

    assign sel         = johnson_decode(sw_i);
    assign level_nxt_o = (frame_end_i && sel.ok) ? sel.lvl : level_q_o;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            level_q_o <= LEVEL_DARK;
            ok_o      <= 1'b1;
        end else if (frame_end_i) begin
            level_q_o <= level_nxt_o;
            ok_o      <= sel.ok;
        end
    end

endmodule

// File: rtl/dimmer_johnson_pwm.sv
module dimmer_johnson_pwm
    import dim_pkg::*;
#(
    parameter int CLK_DIV        = 4,
    parameter int TICKS_PER_STEP = 16,
    parameter int LED_COUNT      = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [7:0]           sw_i,
    output logic [LED_COUNT-1:0] led_o,
    output logic                 level_ok_o
);
    logic   step_en;
    logic   frame_end;
    step_t  step_q;
    step_t  step_nxt;
    level_t level_q;
    level_t level_nxt;
    duty_t  duty_nxt;
    logic   on_nxt;
    logic [LED_COUNT-1:0] led_q;

    dim_prescaler #(
        .CLK_DIV       (CLK_DIV),
        .TICKS_PER_STEP(TICKS_PER_STEP)
    ) u_presc (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .step_en_o(step_en)
    );

    dim_frame u_frame (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .step_en_i  (step_en),
        .step_q_o   (step_q),
        .step_nxt_o (step_nxt),
        .frame_end_o(frame_end)
    );

    dim_level_select u_level (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sw_i       (sw_i),
        .frame_end_i(frame_end),
        .level_q_o  (level_q),
        .level_nxt_o(level_nxt),
        .ok_o       (level_ok_o)
    );

    // Lit phase sits at the tail of the frame; full duty bypasses the compare.
    assign duty_nxt = duty_of(level_nxt);
    assign on_nxt   = (duty_nxt == DUTY_FULL) ||
                      ((9'(step_nxt) + 9'(duty_nxt)) >= 9'(STEPS));

    always_ff @(posedge clk_i) begin
        if (rst_i)
            led_q <= '0;
        else
            led_q <= {LED_COUNT{on_nxt}};
    end

    assign led_o = led_q;

endmodule

// File: rtl/dimmer_johnson_pwm_chk.sv
module dimmer_johnson_pwm_chk
    import dim_pkg::*;
#(
    parameter int LED_COUNT = 16
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 step_en_i,
    input logic                 frame_end_i,
    input step_t                step_q_i,
    input level_t               level_q_i,
    input logic                 ok_i,
    input logic [LED_COUNT-1:0] led_i
);
    // R5: the selected step only moves on a frame boundary
    p_level_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_end_i |=> $stable(level_q_i));

    // R6: the legality flag only moves on a frame boundary
    p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_end_i |=> $stable(ok_i));

    // R3: the step counter advances only on a prescaler enable
    p_step_pace_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_en_i |=> $stable(step_q_i));

    // R4: the brightest step keeps every line lit
    p_full_on_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (level_q_i == 4'd0) |-> (&led_i));

    // R4: the darkest step keeps every line dark
    p_full_off_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (level_q_i == LEVEL_DARK) |-> (led_i == '0));

endmodule

bind dimmer_johnson_pwm dimmer_johnson_pwm_chk #(.LED_COUNT(LED_COUNT)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .step_en_i  (step_en),
    .frame_end_i(frame_end),
    .step_q_i   (step_q),
    .level_q_i  (level_q),
    .ok_i       (level_ok_o),
    .led_i      (led_o)
);

// File: tb/test_dimmer_johnson_pwm.sv
`timescale 1ns/1ps
module test_dimmer_johnson_pwm;

    localparam int CLK_DIV = 2;
    localparam int TICKS   = 2;
    localparam int LEDS    = 16;
    localparam int STEP    = CLK_DIV * TICKS;
    localparam int FRAME   = 256 * STEP;
    localparam int NVEC    = 19;

    // {legal, index, switch word}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 4'd0,  8'h00}, {1'b1, 4'd15, 8'h80}, {1'b1, 4'd7,  8'h7F},
        {1'b1, 4'd8,  8'hFF}, {1'b0, 4'd0,  8'h55}, {1'b1, 4'd3,  8'h07},
        {1'b1, 4'd12, 8'hF0}, {1'b0, 4'd0,  8'h81}, {1'b1, 4'd1,  8'h01},
        {1'b1, 4'd14, 8'hC0}, {1'b1, 4'd2,  8'h03}, {1'b1, 4'd10, 8'hFC},
        {1'b0, 4'd0,  8'h3C}, {1'b1, 4'd4,  8'h0F}, {1'b1, 4'd9,  8'hFE},
        {1'b1, 4'd5,  8'h1F}, {1'b1, 4'd13, 8'hE0}, {1'b1, 4'd6,  8'h3F},
        {1'b1, 4'd11, 8'hF8}
    };

    localparam logic [7:0] DUTY [16] = '{
        8'hFF, 8'hBF, 8'h99, 8'h7F, 8'h6A, 8'h5A, 8'h4C, 8'h3F,
        8'h34, 8'h2B, 8'h22, 8'h1A, 8'h13, 8'h0C, 8'h05, 8'h00
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      sw  = 8'h00;
    logic [LEDS-1:0] led;
    logic            ok;

    int cyc;
    int checks = 0;
    int fails  = 0;
    int wd     = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dimmer_johnson_pwm #(
        .CLK_DIV       (CLK_DIV),
        .TICKS_PER_STEP(TICKS),
        .LED_COUNT     (LEDS)
    ) i_dimmer_johnson_pwm (
        .clk_i     (clk),
        .rst_i     (rst),
        .sw_i      (sw),
        .led_o     (led),
        .level_ok_o(ok)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input bit good, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 200000) begin
            check(1'b0, "WATCHDOG", "run length", wd, 200000);
            finish_run();
        end
    end

    // Count lit clocks over one boundary-aligned frame; optionally disturb the
    // switches in mid-frame and restore them before the closing boundary.
    task automatic measure(output int ones, output bit uniform,
                           output bit first, output bit last,
                           input bit disturb, input logic [7:0] keep);
        ones = 0; uniform = 1; first = 0; last = 0;
        while (cyc % FRAME != 0) @(negedge clk);
        for (int i = 0; i < FRAME; i++) begin
            if (led[0]) ones++;
            if (led != {LEDS{led[0]}}) uniform = 0;
            if (i == 0) first = led[0];
            if (i == FRAME - 1) last = led[0];
            if (disturb && i == FRAME / 2) sw = ~keep;
            if (disturb && i == FRAME - 4) sw = keep;
            @(negedge clk);
        end
    endtask

    function automatic int lit_clocks(input logic [7:0] d);
        return (d == 8'hFF) ? FRAME : int'(d) * STEP;
    endfunction

    initial begin
        int ones;
        bit uni, fst, lst;
        logic [7:0] cur_duty;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R8: reset state visible before the first active edge
        check(led == '0, "R8", "led after reset", int'(led), 0);
        check(ok == 1'b1, "R8", "flag after reset", int'(ok), 1);
        // R8: first frame dark although switches ask for full brightness
        measure(ones, uni, fst, lst, 1'b0, 8'h00);
        check(ones == 0, "R8", "lit clocks in frame 0", ones, 0);
        cur_duty = 8'h00;

        for (int v = 0; v < NVEC; v++) begin
            logic       legal;
            logic [3:0] idx;
            logic [7:0] word;
            {legal, idx, word} = VEC[v];
            while (cyc % FRAME != FRAME / 2) @(negedge clk);
            sw = word;
            if (legal) cur_duty = DUTY[idx];
            measure(ones, uni, fst, lst, 1'b1, word);
            // R1 / R6: legality flag after the sampling boundary
            check(ok == legal, legal ? "R1" : "R6", "level_ok_o", int'(ok), int'(legal));
            // R2 / R3 / R5 / R9: lit clocks over the full frame (mid-frame change ignored)
            check(ones == lit_clocks(cur_duty), legal ? "R2" : "R6",
                  "lit clocks", ones, lit_clocks(cur_duty));
            // R7: identical lines
            check(uni, "R7", "lines identical", int'(uni), 1);
            if (cur_duty != 8'h00 && cur_duty != 8'hFF) begin
                // R3: dark phase first, lit phase last
                check(fst == 1'b0 && lst == 1'b1, "R3", "phase order",
                      int'({fst, lst}), 1);
            end else begin
                // R4: no pulse at the frame edges for the extreme duties
                check(fst == lst && fst == (cur_duty == 8'hFF), "R4",
                      "edge samples", int'({fst, lst}), (cur_duty == 8'hFF) ? 3 : 0);
            end
        end

        // R9 / R5: mid-run reset then full brightness
        sw = 8'h00;
        while (cyc % FRAME != FRAME / 3) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(led == '0, "R8", "led after mid-run reset", int'(led), 0);
        measure(ones, uni, fst, lst, 1'b0, 8'h00);
        check(ones == 0, "R8", "dark frame after mid-run reset", ones, 0);
        measure(ones, uni, fst, lst, 1'b0, 8'h00);
        check(ones == FRAME && fst, "R9", "full frame after reset", ones, FRAME);

        finish_run();
    end

endmodule